// File: doc/BRIEF.md
# Clock Multiplier Configuration Sequencer

This block is the register front end of an on-chip clock multiplier. Software turns on one or more reference sources, writes a multiplication factor (1 to 31) and one of four reference selections, waits for the selected reference to settle, and then sets the multiplier enable. The oscillator and loop themselves are outside the block. Per-source stable flags, the loop's lock flag and the frequency of the selected reference (in whole MHz) arrive as inputs.

While the multiplier runs, the block freezes its configuration and keeps the enable of the reference in use switched on. It reports the output as usable only when the multiplier is enabled, the selected reference is enabled and stable, and lock is present. A configuration error flag shows when the reference frequency times the factor would give less than the minimum output frequency.

Top module: `pllseq`

## Requirements
- R1: Register map (address on `wr_addr`/`rd_addr`): 0 = reference enables, one bit per source in bits [3:0]; 1 = configuration, with factor in bits [4:0] and source select in bits [6:5]; 2 = control, with multiplier enable in bit 0; 3 = status, read-only, with bit0 ready, bit1 config error, bit2 lock, bit3 selected-reference stable. Unused read bits are 0. `rd_data` is combinational from `rd_addr`.
- R2: After reset, the reference enables read 0x01, configuration reads 0x01 (factor 1, source 0), and control reads 0x00.
- R3: A configuration write takes effect at the next clock edge when the multiplier is disabled and the written factor is non-zero.
- R4: A configuration write with factor 0 is ignored in full, and the previous factor and source are kept.
- R5: While the multiplier is enabled, configuration writes are ignored, and the readback value does not change.
- R6: While the multiplier is enabled, a write to the reference enables cannot clear the bit of the selected source. The other bits take the written value.
- R7: A write that sets the multiplier enable is ignored unless the selected reference's enable bit is already set. Clearing the enable is always accepted.
- R8: `ready` is high exactly when the multiplier is enabled, the selected reference is enabled, its stable input is high and `lock` is high. It falls in the same cycle that lock or stable drops, and in the cycle after the enable is cleared.
- R9: `cfg_err` is high when `ref_mhz` times the factor is below MIN_MHZ (default 10). It does not gate `ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data |
| ref_stable | input | 4 | Per-source stable flags |
| lock | input | 1 | Loop lock flag |
| ref_mhz | input | 5 | Selected reference frequency in MHz |
| ref_en | output | 4 | Reference source enables |
| mul_factor | output | 5 | Multiplication factor |
| ref_sel | output | 2 | Selected reference |
| mul_en | output | 1 | Multiplier enable |
| ready | output | 1 | Multiplier output usable |
| cfg_err | output | 1 | Output frequency below minimum |

## Verification
The assertions check on every cycle that the configuration stays frozen and the active reference stays enabled while the multiplier runs. They also check that the factor never becomes zero, that ready implies lock and a stable reference, and that ready falls once the enable drops. The bench scenarios cover what no single-cycle property can show. These are the accepted and rejected write patterns as seen through readback, the refused enable without a reference, the frequency-error threshold at several products, and the register values after reset.

// File: rtl/pllseq.sv
module pllseq #(
  parameter int NSRC    = 4,
  parameter int FAC_W   = 5,
  parameter int FREQ_W  = 5,
  parameter int MIN_MHZ = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [1:0]               wr_addr,
  input  logic [7:0]               wr_data,
  input  logic [1:0]               rd_addr,
  output logic [7:0]               rd_data,
  input  logic [NSRC-1:0]          ref_stable,
  input  logic                     lock,
  input  logic [FREQ_W-1:0]        ref_mhz,
  output logic [NSRC-1:0]          ref_en,
  output logic [FAC_W-1:0]         mul_factor,
  output logic [$clog2(NSRC)-1:0]  ref_sel,
  output logic                     mul_en,
  output logic                     ready,
  output logic                     cfg_err
);
  localparam int SEL_W  = $clog2(NSRC);
  localparam int PROD_W = FAC_W + FREQ_W;

  logic [NSRC-1:0]  sel_oh;
  logic [FAC_W-1:0] wr_fac;
  logic [SEL_W-1:0] wr_sel;
  logic [PROD_W-1:0] f_out;

  assign sel_oh = NSRC'(1) << ref_sel;
  assign wr_fac = wr_data[FAC_W-1:0];
  assign wr_sel = wr_data[FAC_W +: SEL_W];
  assign f_out  = PROD_W'(ref_mhz) * PROD_W'(mul_factor);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_en     <= NSRC'(1);
      mul_factor <= FAC_W'(1);
      ref_sel    <= '0;
      mul_en     <= 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        2'd0: ref_en <= wr_data[NSRC-1:0] | (mul_en ? sel_oh : '0);
        2'd1: if (!mul_en && wr_fac != '0) begin
                mul_factor <= wr_fac;
                ref_sel    <= wr_sel;
              end
        2'd2: if (!wr_data[0] || ref_en[ref_sel]) mul_en <= wr_data[0];
        default: ;
      endcase
    end
  end

  assign ready   = mul_en & ref_en[ref_sel] & ref_stable[ref_sel] & lock;
  assign cfg_err = f_out < PROD_W'(MIN_MHZ);

  always_comb begin
    case (rd_addr)
      2'd0:    rd_data = 8'(ref_en);
      2'd1:    rd_data = 8'({ref_sel, mul_factor});
      2'd2:    rd_data = 8'(mul_en);
      default: rd_data = {4'b0, ref_stable[ref_sel], lock, cfg_err, ready};
    endcase
  end
endmodule

module pllseq_chk #(
  parameter int NSRC  = 4,
  parameter int FAC_W = 5
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     mul_en,
  input logic                     ready,
  input logic                     lock,
  input logic [NSRC-1:0]          ref_stable,
  input logic [NSRC-1:0]          ref_en,
  input logic [$clog2(NSRC)-1:0]  ref_sel,
  input logic [FAC_W-1:0]         mul_factor
);
  assert_cfg_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mul_en |=> $stable(mul_factor) && $stable(ref_sel));
  assert_active_ref_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mul_en |=> ref_en[ref_sel]);
  assert_factor_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mul_factor != '0);
  assert_ready_needs_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> lock && ref_stable[ref_sel]);
  assert_ready_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mul_en) |-> !ready);
  assert_enable_needs_ref_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mul_en) |-> ref_en[ref_sel]);
endmodule

bind pllseq pllseq_chk #(.NSRC(NSRC), .FAC_W(FAC_W)) chk_i (.*);

// File: tb/pllseq_tb.sv
module pllseq_tb_top;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       wr_en = 0;
  logic [1:0] wr_addr = 0;
  logic [7:0] wr_data = 0;
  logic [1:0] rd_addr = 0;
  logic [7:0] rd_data;
  logic [3:0] ref_stable = 4'hF;
  logic       lock = 1;
  logic [4:0] ref_mhz = 5'd2;
  logic [3:0] ref_en;
  logic [4:0] mul_factor;
  logic [1:0] ref_sel;
  logic       mul_en, ready, cfg_err;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  pllseq dut_i (.*);

  // {wr_addr, wr_data, rd_addr, expected rd_data}
  localparam int NV = 12;
  localparam logic [19:0] VEC [NV] = '{
    {2'd0, 8'h03, 2'd0, 8'h03},   // R6 free write while disabled
    {2'd1, 8'h28, 2'd1, 8'h28},   // R3 sel1 fac8
    {2'd1, 8'h40, 2'd1, 8'h28},   // R4 factor 0 ignored
    {2'd2, 8'h01, 2'd3, 8'h0D},   // R8 ready, R9 16 >= 10
    {2'd1, 8'h25, 2'd1, 8'h28},   // R5 frozen while enabled
    {2'd0, 8'h00, 2'd0, 8'h02},   // R6 active bit kept
    {2'd2, 8'h00, 2'd3, 8'h0C},   // R8 ready off after disable
    {2'd1, 8'h44, 2'd1, 8'h44},   // R3 sel2 fac4
    {2'd0, 8'h00, 2'd0, 8'h00},   // R6 clearing allowed when disabled
    {2'd2, 8'h01, 2'd2, 8'h00},   // R7 refused, ref2 off
    {2'd0, 8'h04, 2'd3, 8'h0E},   // R9 8 < 10
    {2'd2, 8'h01, 2'd3, 8'h0F}    // R7 accepted, R9 err does not gate ready
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input string req, input logic [1:0] a, input logic [7:0] exp);
    rd_addr = a; #1;
    check(req, rd_data, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd("R2", 2'd0, 8'h01);
    rd("R2", 2'd1, 8'h01);
    rd("R2", 2'd2, 8'h00);
    rd("R1", 2'd3, 8'h0E);  // err (2*1<10), lock, stable
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][19:18], VEC[i][17:10]);
      rd("R1/R3-R9 vector", VEC[i][9:8], VEC[i][7:0]);
    end
    // now enabled on sel2 fac4, ref_mhz 2
    lock = 0; #1;
    check("R8 lock drop", {7'b0, ready}, 8'h00);
    lock = 1; ref_stable = 4'b1011; #1;
    check("R8 stable drop", {7'b0, ready}, 8'h00);
    ref_stable = 4'hF; ref_mhz = 5'd3; #1;
    check("R9 3*4 >= 10", {7'b0, cfg_err}, 8'h00);
    check("R8 ready back", {7'b0, ready}, 8'h01);
    wr(2'd0, 8'h01);
    rd("R6 ref2 kept", 2'd0, 8'h05);
    ref_mhz = 5'd2;
    wr(2'd2, 8'h00);
    wr(2'd1, 8'h3F);  // sel1 fac31
    rd("R3 max factor", 2'd1, 8'h3F);
    ref_mhz = 5'd0; #1;
    check("R9 zero ref", {7'b0, cfg_err}, 8'h01);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    rd("R2 reset again", 2'd1, 8'h01);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule